// File: doc/BRIEF.md
# Flash Command Sequencer with Full Status

This block sits between a processor's bus write cycles and a flash array controller. Software issues commands as one or two writes. The first write's low byte selects the command. The second write confirms the command, or supplies the address and data for a program. The block checks the target block against a per-block lock table. An override input can bypass that table. The block then hands an abstract auto-operation to an external array stub through a start/done/fail handshake.

The result of every command ends up in two sticky flags, `err_erase` and `err_prog`. Read together as `{err_erase, err_prog}`, the flags mean:

- `00`: no error.
- `11`: a malformed command sequence.
- `10`: an erase was refused or failed.
- `01`: a program or lock-bit program was refused or failed.

While an operation runs, the block reports busy and drops every bus write.

The block address is the top `BW` bits of the bus address. First-cycle codes (low byte) are:

| Code | Command |
|------|---------|
| 40h | program |
| 20h | block erase |
| A7h | erase all unlocked blocks |
| 77h | lock bit program |
| FFh | read array |
| 50h | clear status |

The upper data byte is ignored in every command cycle except the program data cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset both error flags are 0, `busy` and `op_start` are 0, and every block is locked.
- R2: A program takes two writes: first low byte 40h, then a second write whose address and full 16-bit data appear on `op_addr`/`op_data`. On the cycle after that second write, `op_start` pulses with `op_kind` = 0.
- R3: A block erase (20h), erase-all (A7h) or lock bit program (77h) launches only when the second write has low byte D0h. The launch uses `op_kind` 1, 2 or 3 and the second write's address.
- R4: A low byte FFh in the second write drops the pending command with no error and no launch. A first-cycle FFh changes nothing.
- R5: Either of these sets both error flags and launches nothing: a second-cycle low byte other than D0h or FFh for a two-cycle erase or lock command, or an unrecognised first-cycle code.
- R6: A block erase to a locked block, with `lock_off` = 0, sets only `err_erase` and launches nothing.
- R7: A program to a locked block, with `lock_off` = 0, sets only `err_prog` and launches nothing.
- R8: With `lock_off` = 1, locked blocks raise no lock error and the operation launches.
- R9: When `op_fail` accompanies `op_done`, an erase kind sets `err_erase` only, and a program or lock-program kind sets `err_prog` only.
- R10: The error flags are sticky. Only a first-cycle 50h or reset clears them.
- R11: `busy` is high from the launch cycle until the cycle after `op_done`. Bus writes during that time have no effect.
- R12: These operations update the lock table on success:
  - a lock bit program locks its block;
  - a block erase unlocks its block;
  - an erase-all launched with `lock_off` = 1 unlocks every block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Bus write address; top BW bits select the block |
| wr_data | input | 16 | Bus write data |
| lock_off | input | 1 | 1 = ignore lock bits |
| busy | output | 1 | Auto-operation in progress |
| err_erase | output | 1 | Sticky erase/sequence error flag |
| err_prog | output | 1 | Sticky program/sequence error flag |
| op_start | output | 1 | One-cycle launch pulse to the array stub |
| op_kind | output | 2 | 0 program, 1 block erase, 2 erase all, 3 lock program |
| op_addr | output | AW | Target address of the operation |
| op_data | output | 16 | Program data |
| op_done | input | 1 | Array stub reports completion |
| op_fail | input | 1 | Qualifies op_done as a failure |

## Verification
The assertions assume the array stub raises `op_done` only while `busy` is high, and raises `op_fail` only together with `op_done`. They also assume `wr_en` is a single-cycle strobe per write. The directed stimulus follows these rules: it drives `op_done` for exactly one cycle, some time after each launch, and never otherwise. Writes issued while busy are deliberate, so the ignore rule can be observed at the flags and the launch outputs.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 12,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          lock_off,
  output logic          busy,
  output logic          err_erase,
  output logic          err_prog,
  output logic          op_start,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data,
  input  logic          op_done,
  input  logic          op_fail
);
  localparam int NB = 1 << BW;
  localparam logic [7:0] C_PROG = 8'h40, C_ERASE = 8'h20, C_ALL = 8'hA7,
                         C_LOCK = 8'h77, C_READ = 8'hFF, C_CLR = 8'h50, C_OK = 8'hD0;

  typedef enum logic [1:0] {S_IDLE, S_CONF, S_BUSY} st_t;

  st_t           st;
  logic [7:0]    pend;
  logic [NB-1:0] locked;
  logic          ovr;

  wire [7:0]    lo      = wr_data[7:0];
  wire [BW-1:0] wblk    = wr_addr[AW-1 -: BW];
  wire [BW-1:0] oblk    = op_addr[AW-1 -: BW];
  wire          wlocked = locked[wblk] & ~lock_off;
  wire          fin     = (st == S_BUSY) && op_done;

  logic go, seq, e_set, p_set, to_conf, clr;
  logic [1:0] gk;

  always_comb begin
    go = 1'b0; gk = 2'd0; seq = 1'b0; e_set = 1'b0; p_set = 1'b0;
    to_conf = 1'b0; clr = 1'b0;
    if (wr_en && st == S_IDLE) begin
      case (lo)
        C_READ: ;
        C_CLR: clr = 1'b1;
        C_PROG, C_ERASE, C_ALL, C_LOCK: to_conf = 1'b1;
        default: seq = 1'b1;
      endcase
    end else if (wr_en && st == S_CONF) begin
      if (pend == C_PROG) begin
        if (wlocked) p_set = 1'b1;
        else go = 1'b1;
      end else if (lo == C_OK) begin
        case (pend)
          C_ERASE: if (wlocked) e_set = 1'b1; else begin go = 1'b1; gk = 2'd1; end
          C_ALL:   begin go = 1'b1; gk = 2'd2; end
          default: begin go = 1'b1; gk = 2'd3; end
        endcase
      end else if (lo != C_READ) begin
        seq = 1'b1;
      end
    end
  end

  wire fail_e = fin && op_fail && (op_kind == 2'd1 || op_kind == 2'd2);
  wire fail_p = fin && op_fail && (op_kind == 2'd0 || op_kind == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend      <= '0;
      locked    <= '1;
      ovr       <= 1'b0;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      op_start  <= 1'b0;
      op_kind   <= '0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      op_start  <= go;
      err_erase <= clr ? 1'b0 : (err_erase | seq | e_set | fail_e);
      err_prog  <= clr ? 1'b0 : (err_prog  | seq | p_set | fail_p);
      if (to_conf) begin
        st   <= S_CONF;
        pend <= lo;
      end else if (st == S_CONF && wr_en) begin
        st <= go ? S_BUSY : S_IDLE;
      end
      if (go) begin
        op_kind <= gk;
        op_addr <= wr_addr;
        op_data <= wr_data;
        ovr     <= lock_off;
      end
      if (fin) begin
        st <= S_IDLE;
        if (!op_fail) begin
          case (op_kind)
            2'd1: locked[oblk] <= 1'b0;
            2'd2: if (ovr) locked <= '0;
            2'd3: locked[oblk] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign busy = (st == S_BUSY);

  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy);
  a_r11_busy_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && !op_done |=> $stable({err_erase, err_prog}) && $stable(op_addr) && !op_start);
  a_r10_sticky_erase: assert property (@(posedge clk) disable iff (!rst_n)
    err_erase && !(wr_en && st == S_IDLE && wr_data[7:0] == C_CLR) |=> err_erase);
  a_r10_sticky_prog: assert property (@(posedge clk) disable iff (!rst_n)
    err_prog && !(wr_en && st == S_IDLE && wr_data[7:0] == C_CLR) |=> err_prog);
  a_r7_no_locked_program: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && op_kind == 2'd0 |-> !locked[oblk] || ovr);
  a_r6_locked_erase: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CONF && pend == C_ERASE && wr_en && wr_data[7:0] == C_OK && locked[wblk] && !lock_off
    |=> err_erase && !op_start);
  a_r9_program_fail: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_done && op_fail && op_kind == 2'd0 |=> err_prog);
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, lock_off = 1'b0, op_done = 1'b0, op_fail = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, err_erase, err_prog, op_start;
  logic [1:0] op_kind;
  logic [11:0] op_addr;
  logic [15:0] op_data;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(12), .BW(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_off(lock_off), .busy(busy), .err_erase(err_erase), .err_prog(err_prog),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .op_done(op_done), .op_fail(op_fail));

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_op(input logic f);
    @(negedge clk); op_done = 1'b1; op_fail = f;
    @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
  endtask

  task automatic flags(input string r, input logic e, input logic p);
    chk(r, "err_erase", err_erase, e);
    chk(r, "err_prog", err_prog, p);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0);
    chk("R1", "op_start", op_start, 0);
    flags("R1", 0, 0);
  endtask

  task automatic t_locked_program;
    wr(12'h010, 16'h0040); wr(12'h010, 16'h1234);
    chk("R7", "op_start", op_start, 0);
    flags("R7", 0, 1);
    wr(12'h000, 16'h0050);
    flags("R10", 0, 0);
  endtask

  task automatic t_locked_erase;
    wr(12'h000, 16'h0020); wr(12'h000, 16'h00D0);
    chk("R6", "op_start", op_start, 0);
    flags("R6", 1, 0);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_sequence;
    wr(12'h000, 16'h0077); wr(12'h000, 16'h0033);
    chk("R5", "op_start", op_start, 0);
    flags("R5", 1, 1);
    wr(12'h000, 16'h00FF);
    flags("R10", 1, 1);
    wr(12'h000, 16'h0050);
    wr(12'h000, 16'h0012);
    flags("R5", 1, 1);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_abandon;
    wr(12'h400, 16'h0020); wr(12'h400, 16'h55FF);
    chk("R4", "busy", busy, 0);
    chk("R4", "op_start", op_start, 0);
    flags("R4", 0, 0);
    wr(12'h400, 16'h00D0);
    flags("R4", 1, 1);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_override_busy;
    wr(12'h000, 16'h0012);
    lock_off = 1'b1;
    wr(12'h400, 16'h0020); wr(12'h400, 16'hABD0);
    chk("R8", "op_start", op_start, 1);
    chk("R3", "op_kind", op_kind, 1);
    chk("R3", "op_addr", op_addr, 12'h400);
    chk("R11", "busy", busy, 1);
    lock_off = 1'b0;
    wr(12'h000, 16'h0050);
    flags("R11", 1, 1);
    chk("R11", "busy held", busy, 1);
    finish_op(1'b0);
    chk("R11", "busy after done", busy, 0);
    flags("R11", 1, 1);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_program_ops;
    wr(12'h404, 16'h0040); wr(12'h404, 16'hBEEF);
    chk("R12", "op_start unlocked", op_start, 1);
    chk("R2", "op_kind", op_kind, 0);
    chk("R2", "op_addr", op_addr, 12'h404);
    chk("R2", "op_data", op_data, 16'hBEEF);
    finish_op(1'b1);
    flags("R9", 0, 1);
    wr(12'h000, 16'h0050);
    wr(12'h400, 16'h0020); wr(12'h400, 16'h00D0);
    chk("R3", "erase start", op_start, 1);
    finish_op(1'b1);
    flags("R9", 1, 0);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_lock_program;
    wr(12'h400, 16'h0077); wr(12'h400, 16'h00D0);
    chk("R3", "op_kind", op_kind, 3);
    finish_op(1'b0);
    flags("R12", 0, 0);
    wr(12'h400, 16'h0040); wr(12'h400, 16'h0001);
    chk("R12", "relocked start", op_start, 0);
    flags("R12", 0, 1);
    wr(12'h000, 16'h0050);
    wr(12'h800, 16'h0077); wr(12'h800, 16'h00D0);
    finish_op(1'b1);
    flags("R9", 0, 1);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_erase_all;
    wr(12'h000, 16'h00A7); wr(12'h000, 16'h00D0);
    chk("R3", "op_kind", op_kind, 2);
    finish_op(1'b0);
    wr(12'h800, 16'h0040); wr(12'h800, 16'h0002);
    flags("R12", 0, 1);
    wr(12'h000, 16'h0050);
    lock_off = 1'b1;
    wr(12'h000, 16'h00A7); wr(12'h000, 16'h00D0);
    lock_off = 1'b0;
    finish_op(1'b0);
    wr(12'h800, 16'h0040); wr(12'h800, 16'h0002);
    chk("R12", "unlocked all", op_start, 1);
    flags("R12", 0, 0);
    finish_op(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_locked_program;
    t_locked_erase;
    t_sequence;
    t_abandon;
    t_override_busy;
    t_program_ops;
    t_lock_program;
    t_erase_all;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule